// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is the command interpreter of a serial NOR flash slave, working one byte at a time. A frame opens when `csStart` pulses. The first byte of the frame is an opcode. Depending on the opcode, the engine then collects address, dummy or argument bytes. After that it either streams array contents, ANDs incoming bytes into the array, erases an aligned region, or returns a short register reply. Each transfer carries one byte in on `byteIn` while `byteValid` is high. The byte returned for that transfer appears on `byteOut` after the same clock edge.

The storage is a small register array inside the block. Its size is `2**MEM_AW` bytes. The three erase granules are likewise sized by parameters. Addresses are 3 or 4 bytes long. In 3-byte mode an 8-bit extended-address register supplies the top byte. Every assembled address is reduced modulo the array size. The block also provides:
- a write-enable latch that guards all array changes;
- a status/configuration write that takes effect only when the next frame opens;
- an identification reply;
- a two-step software reset.

Top module: `flash_cmd_engine`

## Requirements
- R1: After hardware reset, `byteOut` is 0x00 and the write-enable latch is clear. The engine is in 3-byte mode with the extended-address register at 0x00 and the configuration byte at `CFG_RESET` (0x07). Every array byte reads 0xFF.
- R2: `byteOut` changes only on a clock edge where `byteValid` is high, and it holds its value otherwise. The reply to an opcode, address, dummy or program-data byte is 0x00.
- R3: Read opcodes and their address lengths: 0x03 uses the current mode, 0x13 always uses 4 address bytes, 0x0B uses the current mode plus `DUMMY_BYTES` dummy bytes, and 0x0C uses 4 address bytes plus the dummy bytes. Each byte after the address and dummy bytes returns the array byte at the current address. The address then advances and wraps from `2**MEM_AW-1` to 0.
- R4: Opcodes 0x13, 0x0C, 0x12, 0x3E, 0x21, 0x5C and 0xDC always take 4 address bytes. Every other address opcode takes 3 bytes, or 4 bytes after 0xB7 (enter 4-byte mode) until 0xE9 (leave 4-byte mode). A 3-byte address gets the extended-address register as its top byte. The address is then masked to `MEM_AW` bits. Opcode 0xC5 writes the extended-address register from one argument byte, and 0xC8 reads it back.
- R5: Program opcodes are 0x02 (address length by mode), 0x12 and 0x3E (4-byte address). Each data byte after the address replaces the byte at the current address with (old AND data) when the write-enable latch is set; with the latch clear the array is unchanged. The address advances and wraps after every data byte.
- R6: Erase opcodes and region sizes: 0x20/0x21 erase `2**SMALL_AW` bytes, 0x52/0x5C erase `2**MID_AW` bytes, and 0xD8/0xDC erase `2**SECTOR_AW` bytes. The region is the aligned one that contains the address, and every byte in it becomes 0xFF after the last address byte. Opcode 0xC7 sets the whole array to 0xFF. Nothing is erased while the write-enable latch is clear.
- R7: 0x06 sets the write-enable latch and 0x04 clears it. The latch also clears when an erase executes, when a frame opens after a program frame, and when a status/configuration write is committed. Opcode 0x05 replies with the latch in bit 1 and zeros elsewhere.
- R8: Opcode 0x15 replies with the configuration byte, with bit 5 replaced by the 4-byte-mode flag.
- R9: Opcode 0x9F replies with the `ID_LEN` bytes of `ID_BYTES`, most significant first. If the top three bytes of `ID_BYTES` are zero, no ID bytes are returned. With the default ID the reply is 01 20 18 4D 01 80.
- R10: Opcode 0x01 is accepted only while the write-enable latch is set. It collects up to two bytes and keeps them until the next `csStart`. At that point the latch clears. If two bytes arrived, the second byte becomes the configuration byte and its bit 5 becomes the 4-byte-mode flag. The first byte and any byte after the second are discarded.
- R11: Opcode 0x99 resets the engine only when the opcode before it was 0x66, whether in the same frame or across a frame boundary. The reset clears the latch, selects 3-byte mode, zeroes the extended-address register and restores `CFG_RESET`. It leaves the array untouched.
- R12: After an unknown opcode, a 0x01 without the latch, or the last byte of a register reply, every further byte of the frame is ignored and replies 0x00.
- R13: `csStart` abandons any partly received command, and the next byte is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csStart | input | 1 | One-cycle pulse opening a new frame |
| byteValid | input | 1 | A transfer byte is present on `byteIn` this cycle |
| byteIn | input | 8 | Byte shifted in from the host |
| byteOut | output | 8 | Byte returned for the most recent transfer |

## Verification
On every cycle the assertions check four things. Program and erase strobes reach the array only while the write-enable latch is set. An erase always drops the latch on the next cycle. Every address sent to the array lies inside it. `byteOut`, the latch and the address mode stay unchanged in cycles with no transfer and no frame start.

Some behaviours need whole byte sequences, and only the bench's scenarios can show them:
- the AND-only programming rule and the address wrap;
- the alignment of each erase granule;
- committing the argument of the status write only when the next frame opens;
- the reset arm being cancelled by an intervening command;
- frames being blocked after unknown opcodes.

The bench compares full-array dumps with a model that it updates from these rules.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_READ,
    ST_COLLECT,
    ST_VARLEN,
    ST_REPLY
  } engState_e;

  typedef enum logic [1:0] {ER_SMALL, ER_MID, ER_SECTOR, ER_ALL} eraseKind_e;

  typedef enum logic [1:0] {RP_STATUS, RP_CONFIG, RP_ID, RP_EXTADDR} replyKind_e;

  typedef enum logic [2:0] {CL_NONE, CL_READ, CL_PROG, CL_ERASE, CL_EXTW} cmdClass_e;

  typedef struct packed {
    cmdClass_e  cls;
    logic       longAddr;
    logic       fast;
    eraseKind_e eraseKind;
  } opInfo_t;

  typedef struct packed {
    logic        prog;
    logic        erase;
    eraseKind_e  kind;
    logic [31:0] addr;
    logic [7:0]  wdata;
  } dpCtl_t;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_RDCFG  = 8'h15;
  localparam logic [7:0] OP_RDID   = 8'h9F;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_EN4B   = 8'hB7;
  localparam logic [7:0] OP_EX4B   = 8'hE9;
  localparam logic [7:0] OP_RDEXT  = 8'hC8;
  localparam logic [7:0] OP_BULK   = 8'hC7;
  localparam logic [7:0] OP_RSTARM = 8'h66;
  localparam logic [7:0] OP_RSTGO  = 8'h99;

  function automatic opInfo_t classify(input logic [7:0] op);
    opInfo_t info;
    info = '{cls: CL_NONE, longAddr: 1'b0, fast: 1'b0, eraseKind: ER_SMALL};
    case (op)
      8'h03: info.cls = CL_READ;
      8'h13: begin info.cls = CL_READ; info.longAddr = 1'b1; end
      8'h0B: begin info.cls = CL_READ; info.fast = 1'b1; end
      8'h0C: begin info.cls = CL_READ; info.fast = 1'b1; info.longAddr = 1'b1; end
      8'h02: info.cls = CL_PROG;
      8'h12, 8'h3E: begin info.cls = CL_PROG; info.longAddr = 1'b1; end
      8'h20: info.cls = CL_ERASE;
      8'h21: begin info.cls = CL_ERASE; info.longAddr = 1'b1; end
      8'h52: begin info.cls = CL_ERASE; info.eraseKind = ER_MID; end
      8'h5C: begin info.cls = CL_ERASE; info.eraseKind = ER_MID; info.longAddr = 1'b1; end
      8'hD8: begin info.cls = CL_ERASE; info.eraseKind = ER_SECTOR; end
      8'hDC: begin info.cls = CL_ERASE; info.eraseKind = ER_SECTOR; info.longAddr = 1'b1; end
      8'hC5: info.cls = CL_EXTW;
      default: info.cls = CL_NONE;
    endcase
    return info;
  endfunction

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_eng_pkg::*;
#(
  parameter int          MEM_AW      = 9,
  parameter int          DUMMY_BYTES = 1,
  parameter logic [7:0]  CFG_RESET   = 8'h07,
  parameter logic [47:0] ID_BYTES    = 48'h01_20_18_4D_01_80,
  parameter int          ID_LEN      = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csStart,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  logic [7:0] rdData,
  output logic [7:0] byteOut,
  output dpCtl_t     dpCtl,
  output logic       wel,
  output logic       fourByte
);

  localparam int MAX_NEED = 4 + DUMMY_BYTES;
  localparam int CNT_W    = $clog2(MAX_NEED + 1);
  localparam int ID_COUNT = (ID_BYTES[47:24] == 24'd0) ? 0 : ID_LEN;

  engState_e          state;
  logic [7:0]         opcode;
  logic [CNT_W-1:0]   need;
  logic [CNT_W-1:0]   cnt;
  logic               addrLong;
  logic [31:0]        acc;
  logic [1:0]         varCnt;
  logic [7:0]         varB1;
  logic [MEM_AW-1:0]  curAddr;
  logic [2:0]         pos;
  logic [2:0]         replyLen;
  replyKind_e         replyKind;
  logic               blocked;
  logic               resetArm;
  logic [7:0]         extAddr;
  logic [7:0]         cfgReg;

  opInfo_t            curInfo;
  opInfo_t            newInfo;
  logic [31:0]        accNext;
  logic [31:0]        fullAddr;
  logic [MEM_AW-1:0]  maskedAddr;
  logic               lastByte;
  logic [7:0]         replyItem;
  logic [7:0]         respByte;
  logic [47:0]        idShift;
  logic [CNT_W-1:0]   addrBytes;

  always_comb begin
    curInfo   = classify(opcode);
    newInfo   = classify(byteIn);
    addrBytes = addrLong ? CNT_W'(4) : CNT_W'(3);
    accNext   = (cnt < addrBytes) ? {acc[23:0], byteIn} : acc;
    fullAddr  = addrLong ? accNext : {extAddr, accNext[23:0]};
    maskedAddr = fullAddr[MEM_AW-1:0];
    lastByte  = ((cnt + CNT_W'(1)) == need);
  end

  always_comb begin
    idShift = ID_BYTES >> (6'd40 - {pos, 3'b000});
    case (replyKind)
      RP_STATUS:  replyItem = {6'b0, wel, 1'b0};
      RP_CONFIG:  replyItem = {cfgReg[7:6], fourByte, cfgReg[4:0]};
      RP_ID:      replyItem = idShift[7:0];
      default:    replyItem = extAddr;
    endcase
    case (state)
      ST_READ:  respByte = rdData;
      ST_REPLY: respByte = replyItem;
      default:  respByte = 8'h00;
    endcase
  end

  always_comb begin
    dpCtl       = '0;
    dpCtl.addr  = 32'(curAddr);
    dpCtl.wdata = byteIn;
    dpCtl.kind  = curInfo.eraseKind;
    if (byteValid && !csStart) begin
      if (state == ST_PROG && wel) dpCtl.prog = 1'b1;
      if (state == ST_COLLECT && lastByte && curInfo.cls == CL_ERASE && wel) begin
        dpCtl.erase = 1'b1;
        dpCtl.addr  = 32'(maskedAddr);
      end
      if (state == ST_IDLE && !blocked && byteIn == OP_BULK && wel) begin
        dpCtl.erase = 1'b1;
        dpCtl.kind  = ER_ALL;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      opcode    <= 8'h00;
      need      <= '0;
      cnt       <= '0;
      addrLong  <= 1'b0;
      acc       <= '0;
      varCnt    <= '0;
      varB1     <= 8'h00;
      curAddr   <= '0;
      pos       <= '0;
      replyLen  <= '0;
      replyKind <= RP_STATUS;
      blocked   <= 1'b0;
      resetArm  <= 1'b0;
      extAddr   <= 8'h00;
      cfgReg    <= CFG_RESET;
      wel       <= 1'b0;
      fourByte  <= 1'b0;
      byteOut   <= 8'h00;
    end else if (csStart) begin
      if (state == ST_VARLEN) begin
        wel <= 1'b0;
        if (varCnt == 2'd2) begin
          cfgReg   <= varB1;
          fourByte <= varB1[5];
        end
      end
      if (state == ST_PROG) wel <= 1'b0;
      state   <= ST_IDLE;
      cnt     <= '0;
      pos     <= '0;
      varCnt  <= '0;
      blocked <= 1'b0;
    end else if (byteValid) begin
      byteOut <= respByte;
      case (state)
        ST_IDLE: begin
          if (!blocked) begin
            opcode   <= byteIn;
            resetArm <= (byteIn == OP_RSTARM);
            cnt      <= '0;
            pos      <= '0;
            case (byteIn)
              OP_WREN:   wel <= 1'b1;
              OP_WRDI:   wel <= 1'b0;
              OP_EN4B:   fourByte <= 1'b1;
              OP_EX4B:   fourByte <= 1'b0;
              OP_RSTARM: ;
              OP_RSTGO: begin
                if (resetArm) begin
                  wel      <= 1'b0;
                  fourByte <= 1'b0;
                  extAddr  <= 8'h00;
                  cfgReg   <= CFG_RESET;
                end
              end
              OP_BULK:   wel <= 1'b0;
              OP_RDSR: begin
                state     <= ST_REPLY;
                replyKind <= RP_STATUS;
                replyLen  <= 3'd1;
              end
              OP_RDCFG: begin
                state     <= ST_REPLY;
                replyKind <= RP_CONFIG;
                replyLen  <= 3'd1;
              end
              OP_RDEXT: begin
                state     <= ST_REPLY;
                replyKind <= RP_EXTADDR;
                replyLen  <= 3'd1;
              end
              OP_RDID: begin
                if (ID_COUNT == 0) begin
                  blocked <= 1'b1;
                end else begin
                  state     <= ST_REPLY;
                  replyKind <= RP_ID;
                  replyLen  <= 3'(ID_COUNT);
                end
              end
              OP_WRSR: begin
                if (wel) begin
                  state  <= ST_VARLEN;
                  varCnt <= '0;
                end else begin
                  blocked <= 1'b1;
                end
              end
              default: begin
                if (newInfo.cls == CL_EXTW) begin
                  state <= ST_COLLECT;
                  need  <= CNT_W'(1);
                end else if (newInfo.cls != CL_NONE) begin
                  state    <= ST_COLLECT;
                  addrLong <= newInfo.longAddr || fourByte;
                  need     <= ((newInfo.longAddr || fourByte) ? CNT_W'(4) : CNT_W'(3))
                              + (newInfo.fast ? CNT_W'(DUMMY_BYTES) : CNT_W'(0));
                end else begin
                  blocked <= 1'b1;
                end
              end
            endcase
          end
        end
        ST_COLLECT: begin
          acc <= accNext;
          cnt <= cnt + CNT_W'(1);
          if (lastByte) begin
            state <= ST_IDLE;
            case (curInfo.cls)
              CL_READ: begin
                state   <= ST_READ;
                curAddr <= maskedAddr;
              end
              CL_PROG: begin
                state   <= ST_PROG;
                curAddr <= maskedAddr;
              end
              CL_ERASE: wel <= 1'b0;
              CL_EXTW:  extAddr <= byteIn;
              default: ;
            endcase
          end
        end
        ST_VARLEN: begin
          if (varCnt != 2'd2) begin
            varCnt <= varCnt + 2'd1;
            if (varCnt == 2'd1) varB1 <= byteIn;
          end
        end
        ST_READ, ST_PROG: curAddr <= curAddr + MEM_AW'(1);
        ST_REPLY: begin
          pos <= pos + 3'd1;
          if ((pos + 3'd1) == replyLen) begin
            state   <= ST_IDLE;
            blocked <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_array_dp.sv
module flash_array_dp
  import flash_eng_pkg::*;
#(
  parameter int MEM_AW    = 9,
  parameter int SMALL_AW  = 4,
  parameter int MID_AW    = 6,
  parameter int SECTOR_AW = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     dpCtl,
  output logic [7:0] rdData
);

  localparam int MEM_BYTES = 1 << MEM_AW;

  logic [7:0]           mem [MEM_BYTES];
  logic [MEM_AW-1:0]    addrLow;
  logic [MEM_BYTES-1:0] eraseHit;
  int unsigned          regAw;

  assign addrLow = dpCtl.addr[MEM_AW-1:0];
  assign rdData  = mem[addrLow];

  always_comb begin
    case (dpCtl.kind)
      ER_SMALL:  regAw = SMALL_AW;
      ER_MID:    regAw = MID_AW;
      ER_SECTOR: regAw = SECTOR_AW;
      default:   regAw = MEM_AW;
    endcase
  end

  for (genvar i = 0; i < MEM_BYTES; i++) begin : g_hit
    localparam logic [MEM_AW-1:0] IDX = MEM_AW'(i);
    assign eraseHit[i] = dpCtl.erase && (((IDX ^ addrLow) >> regAw) == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < MEM_BYTES; i++) begin
        if (eraseHit[i]) mem[i] <= 8'hFF;
        else if (dpCtl.prog && addrLow == MEM_AW'(i)) mem[i] <= mem[i] & dpCtl.wdata;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_eng_pkg::*;
#(
  parameter int          MEM_AW      = 9,
  parameter int          SMALL_AW    = 4,
  parameter int          MID_AW      = 6,
  parameter int          SECTOR_AW   = 7,
  parameter int          DUMMY_BYTES = 1,
  parameter logic [7:0]  CFG_RESET   = 8'h07,
  parameter logic [47:0] ID_BYTES    = 48'h01_20_18_4D_01_80,
  parameter int          ID_LEN      = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csStart,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  output logic [7:0] byteOut
);

  dpCtl_t     dpCtl;
  logic [7:0] rdData;
  logic       wel;
  logic       fourByte;

  flash_cmd_ctrl #(
    .MEM_AW(MEM_AW), .DUMMY_BYTES(DUMMY_BYTES), .CFG_RESET(CFG_RESET),
    .ID_BYTES(ID_BYTES), .ID_LEN(ID_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csStart(csStart), .byteValid(byteValid),
    .byteIn(byteIn), .rdData(rdData), .byteOut(byteOut), .dpCtl(dpCtl),
    .wel(wel), .fourByte(fourByte)
  );

  flash_array_dp #(
    .MEM_AW(MEM_AW), .SMALL_AW(SMALL_AW), .MID_AW(MID_AW), .SECTOR_AW(SECTOR_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .rdData(rdData)
  );

endmodule

// File: rtl/flash_cmd_engine_chk.sv
module flash_cmd_engine_chk
  import flash_eng_pkg::*;
#(
  parameter int MEM_AW = 9
) (
  input logic       clk,
  input logic       rstN,
  input logic       csStart,
  input logic       byteValid,
  input logic [7:0] byteOut,
  input dpCtl_t     dpCtl,
  input logic       wel,
  input logic       fourByte
);

  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> $stable(byteOut));

  p_prog_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.prog |-> wel);

  p_erase_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.erase |-> wel);

  p_erase_drops_wel_r7: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.erase |=> !wel);

  p_addr_in_array_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.prog || dpCtl.erase) |-> ((dpCtl.addr >> MEM_AW) == 32'd0));

  p_mode_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid && !csStart) |=> ($stable(fourByte) && $stable(wel)));

endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rstN(rstN), .csStart(csStart), .byteValid(byteValid),
  .byteOut(byteOut), .dpCtl(dpCtl), .wel(wel), .fourByte(fourByte)
);

// File: tb/flash_cmd_engine_tb.sv
module flash_cmd_engine_tb;

  localparam int N = 512;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csStart = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic [7:0] byteOut;

  int   nChecks = 0;
  int   nFail = 0;
  bit   finished = 1'b0;
  logic [7:0] rx;
  logic [7:0] model [N];

  always #2.5 clk = ~clk;

  flash_cmd_engine u_dut (
    .clk(clk), .rstN(rstN), .csStart(csStart), .byteValid(byteValid),
    .byteIn(byteIn), .byteOut(byteOut)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic csel();
    @(negedge clk); csStart = 1'b1;
    @(negedge clk); csStart = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; byteIn = b;
    @(negedge clk); byteValid = 1'b0; rx = byteOut;
  endtask

  task automatic op1(input logic [7:0] b);
    csel(); xfer(b);
  endtask

  task automatic regRead(input logic [7:0] op, input logic [7:0] exp, input string req);
    csel(); xfer(op); chk(rx, 8'h00, "R2 opcode reply");
    xfer(8'h00); chk(rx, exp, req);
  endtask

  task automatic addr3(input int a);
    xfer(8'(a >> 16)); xfer(8'(a >> 8)); xfer(8'(a));
  endtask

  task automatic dumpAll(input string req);
    csel(); xfer(8'h03); addr3(0);
    for (int i = 0; i < N; i++) begin
      xfer(8'h00); chk(rx, model[i], req);
    end
  endtask

  task automatic eraseModel(input int a, input int sz);
    int base;
    base = (a % N) & ~(sz - 1);
    for (int i = 0; i < sz; i++) model[base + i] = 8'hFF;
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(byteOut, 8'h00, "R1 byteOut at reset");
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset registers and array contents, R3 wrap
    regRead(8'h05, 8'h00, "R1 status after reset");
    regRead(8'h15, 8'h07, "R1 config after reset");
    regRead(8'hC8, 8'h00, "R1 extended address after reset");
    dumpAll("R1 erased array");
    xfer(8'h00); chk(rx, 8'hFF, "R3 read wrap");

    // R5 program without latch
    csel(); xfer(8'h02); addr3(16'h0010); xfer(8'h00); chk(rx, 8'h00, "R2 data reply");
    csel(); xfer(8'h03); addr3(16'h0010); xfer(8'h00); chk(rx, 8'hFF, "R5 no program without latch");

    // R7 latch set, R5 whole-array program with wrap
    op1(8'h06);
    regRead(8'h05, 8'h02, "R7 latch set");
    csel(); xfer(8'h02); addr3(0);
    for (int i = 0; i < N; i++) begin
      xfer(8'(i * 7 + 3));
      model[i] = model[i] & 8'(i * 7 + 3);
    end
    regRead(8'h05, 8'h00, "R7 latch cleared after program frame");

    // R3 fast read with dummy and wrap
    csel(); xfer(8'h0B); addr3(0); xfer(8'hAA); chk(rx, 8'h00, "R2 dummy reply");
    for (int i = 0; i < N; i++) begin
      xfer(8'h00); chk(rx, model[i], "R3 fast read sweep");
    end
    xfer(8'h00); chk(rx, model[0], "R3 fast read wrap");

    // R2 output hold between transfers
    repeat (4) @(negedge clk);
    chk(byteOut, model[0], "R2 output held");

    // R5 AND programming with 4-byte opcodes and wrap
    op1(8'h06);
    csel(); xfer(8'h12); xfer(8'h00); xfer(8'h00); xfer(8'h00); xfer(8'h05); xfer(8'hF0);
    model[5] = model[5] & 8'hF0;
    op1(8'h06);
    csel(); xfer(8'h3E); xfer(8'hFF); xfer(8'hFF); xfer(8'hFF); xfer(8'hFF);
    xfer(8'h0F); xfer(8'h3C);
    model[N-1] = model[N-1] & 8'h0F;
    model[0]   = model[0] & 8'h3C;
    csel(); xfer(8'h13); xfer(8'h77); xfer(8'h77); xfer(8'h01); xfer(8'hFF);
    xfer(8'h00); chk(rx, model[N-1], "R4 4-byte read masked");
    xfer(8'h00); chk(rx, model[0], "R5 program wrap");
    csel(); xfer(8'h03); addr3(5); xfer(8'h00); chk(rx, model[5], "R5 AND rule");

    // R6 erases
    csel(); xfer(8'h20); addr3(16'h0000);
    op1(8'h06); csel(); xfer(8'h20); addr3(16'h0123); eraseModel(16'h0123, 16);
    regRead(8'h05, 8'h00, "R7 latch cleared after erase");
    op1(8'h06); csel(); xfer(8'h5C); xfer(8'h00); xfer(8'h00); xfer(8'h00); xfer(8'hC5);
    eraseModel(16'h00C5, 64);
    op1(8'h06); csel(); xfer(8'hDC); xfer(8'h12); xfer(8'h34); xfer(8'h01); xfer(8'hF0);
    eraseModel(16'h01F0, 128);
    op1(8'h06); csel(); xfer(8'h21); xfer(8'h00); xfer(8'h00); xfer(8'h00); xfer(8'h37);
    eraseModel(16'h0037, 16);
    op1(8'h06); csel(); xfer(8'h52); addr3(16'h0045); eraseModel(16'h0045, 64);
    op1(8'h06); csel(); xfer(8'hD8); addr3(16'h0099); eraseModel(16'h0099, 128);
    dumpAll("R6 region erases");
    op1(8'h06); op1(8'hC7);
    for (int i = 0; i < N; i++) model[i] = 8'hFF;
    dumpAll("R6 bulk erase");

    // R4 address mode and extended address
    op1(8'hB7);
    regRead(8'h15, 8'h27, "R8 config shows 4-byte mode");
    op1(8'h06); csel(); xfer(8'h02); xfer(8'h00); xfer(8'h00); xfer(8'h01); xfer(8'h23); xfer(8'hAA);
    model[16'h123] = 8'hAA;
    csel(); xfer(8'h03); xfer(8'h00); xfer(8'h00); xfer(8'h01); xfer(8'h23);
    xfer(8'h00); chk(rx, 8'hAA, "R4 4-byte mode read");
    op1(8'hE9);
    regRead(8'h15, 8'h07, "R8 config after leaving 4-byte mode");
    csel(); xfer(8'hC5); xfer(8'h5A);
    regRead(8'hC8, 8'h5A, "R4 extended address readback");
    csel(); xfer(8'h03); addr3(16'h0123); xfer(8'h00); chk(rx, 8'hAA, "R4 extended byte masked");

    // R10 status/config write
    csel(); xfer(8'h01); xfer(8'h00); xfer(8'h31);
    regRead(8'h15, 8'h07, "R10 write ignored without latch");
    op1(8'h06); csel(); xfer(8'h01); xfer(8'h00); xfer(8'h31);
    regRead(8'h15, 8'h31, "R10 config committed");
    regRead(8'h05, 8'h00, "R10 latch cleared on commit");
    csel(); xfer(8'h03); xfer(8'h00); xfer(8'h00); xfer(8'h01); xfer(8'h23);
    xfer(8'h00); chk(rx, 8'hAA, "R10 bit5 sets 4-byte mode");
    op1(8'h06); csel(); xfer(8'h01); xfer(8'h55);
    regRead(8'h15, 8'h31, "R10 single byte leaves config");
    op1(8'h06); csel(); xfer(8'h01); xfer(8'h00); xfer(8'h07); xfer(8'hFF);
    regRead(8'h15, 8'h07, "R10 third byte discarded");

    // R11 software reset
    op1(8'h06); op1(8'hB7); csel(); xfer(8'hC5); xfer(8'h33);
    op1(8'h66); op1(8'h99);
    regRead(8'h15, 8'h07, "R11 config restored");
    regRead(8'h05, 8'h00, "R11 latch cleared");
    regRead(8'hC8, 8'h00, "R11 extended address cleared");
    csel(); xfer(8'h03); addr3(16'h0123); xfer(8'h00); chk(rx, 8'hAA, "R11 array kept");
    op1(8'h06); op1(8'h66);
    regRead(8'h05, 8'h02, "R7 status with latch");
    op1(8'h99);
    regRead(8'h05, 8'h02, "R11 arm cancelled");
    csel(); xfer(8'h66); xfer(8'h99);
    regRead(8'h05, 8'h00, "R11 reset in one frame");

    // R9 identification
    csel(); xfer(8'h9F);
    xfer(8'h00); chk(rx, 8'h01, "R9 id byte 0");
    xfer(8'h00); chk(rx, 8'h20, "R9 id byte 1");
    xfer(8'h00); chk(rx, 8'h18, "R9 id byte 2");
    xfer(8'h00); chk(rx, 8'h4D, "R9 id byte 3");
    xfer(8'h00); chk(rx, 8'h01, "R9 id byte 4");
    xfer(8'h00); chk(rx, 8'h80, "R9 id byte 5");
    xfer(8'h00); chk(rx, 8'h00, "R12 after id");

    // R12 unknown opcode blocks frame
    csel(); xfer(8'hAB); chk(rx, 8'h00, "R12 unknown reply");
    xfer(8'h06); chk(rx, 8'h00, "R12 blocked reply");
    regRead(8'h05, 8'h00, "R12 blocked byte had no effect");
    csel(); xfer(8'h15); xfer(8'h00); chk(rx, 8'h07, "R8 config reply");
    xfer(8'h06); chk(rx, 8'h00, "R12 overrun reply");
    regRead(8'h05, 8'h00, "R12 overrun byte ignored");

    // R13 frame start abandons partial command
    csel(); xfer(8'h03); xfer(8'h00); xfer(8'h01);
    regRead(8'h15, 8'h07, "R13 decode after abandoned read");
    csel(); xfer(8'h03); addr3(16'h0123); xfer(8'h00); chk(rx, 8'hAA, "R13 read before abandon");
    regRead(8'hC8, 8'h00, "R13 decode after abandoned stream");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule